// File: doc/BRIEF.md
# Serially Programmed Sink/Source Current-Setting Register Bank

This block is the digital side of a bank of current-output DACs. A controller on a two-wire I2C bus writes a setting into each channel register. The register drives the enable and code inputs of an analog current cell. Each setting has two parts: a direction bit that chooses between pushing current out (source) and pulling it in (sink), and a 7-bit magnitude.

The bus lines are sampled on the system clock after synchronization. Two strap pins pick one of four bus addresses, so up to four banks can share one bus. A parameter chooses a two-channel or a four-channel build.

A controller reads a register back by sending a write-mode pointer access, then a repeated START, then a read-mode address. All registers clear to zero on reset, so every current cell starts switched off.

Top module: `i2c_dac_bank`

## Requirements
- R1: The bank answers the 7-bit bus address {addr_strap[1], addr_strap[0], 1, 0, 0, 0, 0}, i.e. write address bytes 20h/60h/A0h/E0h, with bit 0 of the address byte as the direction (0 = write, 1 = read). It acknowledges a matching address byte by pulling SDA low during the ninth clock.
- R2: After an address byte that does not match, the bank neither acknowledges nor changes any register until the next START, even if later bytes look like its own address.
- R3: A write (START, address with bit 0 = 0, pointer byte, data byte, STOP) has all three bytes acknowledged and stores the data byte in channel n when the pointer byte is F8h + n.
- R4: Bit 7 of a channel register selects direction (1 = source, 0 = sink), and bits 6:0 appear on that channel's 7-bit slice of dac_code (channel n at bits 7n+6:7n).
- R5: A channel whose magnitude is zero has both src_en and snk_en low whatever its direction bit; src_en and snk_en of one channel are never high together.
- R6: After reset every channel register reads 00h, all enables and codes are zero, and SDA is released.
- R7: A read (pointer write, repeated START, address with bit 0 = 1) returns the pointed register MSB first, with each bit launched after an SCL falling edge. When the controller NACKs that byte, SDA is released.
- R8: A pointer outside the built channels (any value other than F8h..F8h+channels-1, which in the two-channel build includes FAh and FBh) is still acknowledged. Writes to it are dropped and reads of it return 00h.
- R9: Further data bytes in one write are acknowledged but all land in the same register. The pointer does not advance, and other channels are untouched.
- R10: When the controller ACKs a read byte, the same register is sent again.
- R11: The bank begins pulling SDA low only while SCL is low.
- R12: Channel outputs change only in the cycle after a register write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | High to drive the open-drain data line low |
| addr_strap | input | 2 | Strap pins forming the top two address bits |
| src_en | output | NUM_CH | Per-channel source enable |
| snk_en | output | NUM_CH | Per-channel sink enable |
| dac_code | output | 7*NUM_CH | Per-channel 7-bit magnitude, channel 0 in the low bits |

## Verification
The bench puts two banks on one shared bus. One is the four-channel build strapped to 00, answering 20h. The other is the two-channel build strapped to 01, answering 60h. With this pairing, every channel pointer can be written and read in the full build. The upper pointers FAh/FBh fall out of range in the reduced build. Traffic aimed at one bank must leave the other one's outputs untouched. An unused strap address checks that a bank stays silent until the next START.

// File: rtl/dacbank_pkg.sv
// Package: shared widths and state types for the current-setting register bank.
// Assumes: 8-bit registers, 7-bit magnitude field under a direction bit.
package dacbank_pkg;
    localparam int REG_W  = 8;
    localparam int CODE_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_REGADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_MACK
    } bus_state_e;

    typedef enum logic [1:0] {
        NXT_REG,
        NXT_WDATA,
        NXT_RDATA
    } ack_next_e;
endpackage

// File: rtl/bus_line_sync.sv
// Module: bus_line_sync
// Brings SCL and SDA into the clock domain and flags edges plus START/STOP.
// Assumes: both lines idle high; SYNC_STAGES >= 2 flops per line.
module bus_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic scl_now, scl_prev, sda_now, sda_prev;

    // Shift both lines through their synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_raw};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_raw};
        end
    end

    assign scl_now  = scl_pipe[SYNC_STAGES-1];
    assign scl_prev = scl_pipe[SYNC_STAGES];
    assign sda_now  = sda_pipe[SYNC_STAGES-1];
    assign sda_prev = sda_pipe[SYNC_STAGES];

    // Edge and bus-condition decode from the synchronized levels.
    always_comb begin
        scl_rise  = scl_now & ~scl_prev;
        scl_fall  = ~scl_now & scl_prev;
        sda_lvl   = sda_now;
        start_det = sda_prev & ~sda_now & scl_now & scl_prev;
        stop_det  = ~sda_prev & sda_now & scl_now & scl_prev;
    end
endmodule

// File: rtl/bus_target_fsm.sv
// Module: bus_target_fsm
// Byte-level I2C target: address match, pointer capture, write strobes and
// MSB-first read shifting. Assumes edges arrive already synchronized and that
// SCL stays low for several system clocks.
module bus_target_fsm
    import dacbank_pkg::*;
#(
    parameter logic [4:0] ADDR_LOW = 5'b10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       strap,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_lvl,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] reg_ptr,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_data,
    output logic             sda_pull
);
    bus_state_e       state;
    ack_next_e        ack_next;
    logic [3:0]       bitcnt;
    logic [REG_W-1:0] shreg;
    logic [REG_W-1:0] txreg;
    logic             ctl_nack;
    logic             addr_hit;

    assign addr_hit = (shreg[7:1] == {strap, ADDR_LOW});
    assign wr_data  = shreg;

    // Bus protocol sequencer; START/STOP override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ack_next <= NXT_REG;
            bitcnt   <= '0;
            shreg    <= '0;
            txreg    <= '0;
            ctl_nack <= 1'b1;
            reg_ptr  <= '0;
            wr_en    <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state    <= ST_DEVADDR;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_DEVADDR, ST_REGADDR, ST_WDATA: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[REG_W-2:0], sda_lvl};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (state == ST_DEVADDR) begin
                                if (addr_hit) begin
                                    sda_pull <= 1'b1;
                                    state    <= ST_ACK;
                                    ack_next <= shreg[0] ? NXT_RDATA : NXT_REG;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_REGADDR) begin
                                reg_ptr  <= shreg;
                                sda_pull <= 1'b1;
                                state    <= ST_ACK;
                                ack_next <= NXT_WDATA;
                            end else begin
                                wr_en    <= 1'b1;
                                sda_pull <= 1'b1;
                                state    <= ST_ACK;
                                ack_next <= NXT_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            case (ack_next)
                                NXT_REG:   state <= ST_REGADDR;
                                NXT_WDATA: state <= ST_WDATA;
                                default: begin
                                    state    <= ST_RDATA;
                                    txreg    <= rd_data;
                                    sda_pull <= ~rd_data[7];
                                end
                            endcase
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_pull <= 1'b0;
                                bitcnt   <= '0;
                                state    <= ST_MACK;
                            end else begin
                                txreg    <= {txreg[REG_W-2:0], 1'b0};
                                sda_pull <= ~txreg[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            ctl_nack <= sda_lvl;
                        end else if (scl_fall) begin
                            if (!ctl_nack) begin
                                state    <= ST_RDATA;
                                txreg    <= rd_data;
                                sda_pull <= ~rd_data[7];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/chan_reg_file.sv
// Module: chan_reg_file
// Holds one sign-magnitude setting per channel and decodes it to enables.
// Assumes: channels sit at consecutive pointers from BASE_ADDR; other
// pointers read as zero and ignore writes.
module chan_reg_file
    import dacbank_pkg::*;
#(
    parameter int         NUM_CH    = 4,
    parameter logic [7:0] BASE_ADDR = 8'hF8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [REG_W-1:0]         reg_ptr,
    input  logic [REG_W-1:0]         wr_data,
    output logic [REG_W-1:0]         rd_data,
    output logic [NUM_CH-1:0]        src_en,
    output logic [NUM_CH-1:0]        snk_en,
    output logic [NUM_CH*CODE_W-1:0] dac_code
);
    logic [REG_W-1:0] regs [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        localparam logic [7:0] CH_ADDR = 8'(BASE_ADDR + g);
        logic [CODE_W-1:0] mag;

        // Capture a write aimed at this channel's pointer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && reg_ptr == CH_ADDR) begin
                regs[g] <= wr_data;
            end
        end

        assign mag                            = regs[g][CODE_W-1:0];
        assign dac_code[g*CODE_W +: CODE_W]   = mag;
        assign src_en[g]                      = regs[g][7] & (|mag);
        assign snk_en[g]                      = ~regs[g][7] & (|mag);
    end

    // Read-back mux; unmatched pointers return zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_ptr == 8'(BASE_ADDR + i)) rd_data = regs[i];
        end
    end
endmodule

// File: rtl/i2c_dac_bank.sv
// Module: i2c_dac_bank (top)
// Serial-bus target holding two or four sink/source current settings.
// Assumes: open-drain SDA is realised outside via sda_pull_low; system clock
// runs well above the bus clock.
module i2c_dac_bank
    import dacbank_pkg::*;
#(
    parameter bit FOUR_CH     = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     scl_in,
    input  logic                                     sda_in,
    output logic                                     sda_pull_low,
    input  logic [1:0]                               addr_strap,
    output logic [(FOUR_CH ? 4 : 2)-1:0]             src_en,
    output logic [(FOUR_CH ? 4 : 2)-1:0]             snk_en,
    output logic [(FOUR_CH ? 4 : 2)*CODE_W-1:0]      dac_code
);
    localparam int NUM_CH = FOUR_CH ? 4 : 2;

    logic             scl_rise, scl_fall, sda_lvl, start_det, stop_det;
    logic             wr_en;
    logic [REG_W-1:0] reg_ptr, wr_data, rd_data;

    bus_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
        .start_det(start_det), .stop_det(stop_det)
    );

    bus_target_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .strap(addr_strap),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
        .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
        .reg_ptr(reg_ptr), .wr_en(wr_en), .wr_data(wr_data),
        .sda_pull(sda_pull_low)
    );

    chan_reg_file #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_ptr(reg_ptr),
        .wr_data(wr_data), .rd_data(rd_data), .src_en(src_en),
        .snk_en(snk_en), .dac_code(dac_code)
    );
endmodule

// File: rtl/i2c_dac_bank_chk.sv
// Module: i2c_dac_bank_chk
// Property checker bound into every i2c_dac_bank instance.
module i2c_dac_bank_chk #(
    parameter int NUM_CH = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_in,
    input logic                  sda_pull_low,
    input logic                  wr_en,
    input logic [NUM_CH-1:0]     src_en,
    input logic [NUM_CH-1:0]     snk_en,
    input logic [NUM_CH*7-1:0]   dac_code
);
    assert_dir_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en & snk_en) == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_zero
        assert_zero_mag_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (dac_code[g*7 +: 7] == 7'd0) |-> (!src_en[g] && !snk_en[g]));
    end

    assert_pull_while_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> !scl_in);

    assert_code_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dac_code));

    assert_enable_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(src_en) && $stable(snk_en)));
endmodule

bind i2c_dac_bank i2c_dac_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull_low(sda_pull_low),
    .wr_en(wr_en), .src_en(src_en), .snk_en(snk_en), .dac_code(dac_code)
);

// File: tb/test_i2c_dac_bank.sv
// Bench: a four-channel bank (address 20h) and a two-channel bank (60h)
// share one bus driven by a bit-level controller model.
module test_i2c_dac_bank;
    localparam int CLK_PERIOD = 10;
    localparam int QCLK       = 8;

    typedef struct packed {
        logic [7:0] dev;
        logic [7:0] ptr;
        logic [7:0] data;
        logic [7:0] rd_exp;
        logic       ack_exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'h20, 8'hF8, 8'hAA, 8'hAA, 1'b1},
        '{8'h20, 8'hF9, 8'h05, 8'h05, 1'b1},
        '{8'h20, 8'hFA, 8'h80, 8'h80, 1'b1},
        '{8'h20, 8'hFB, 8'h7F, 8'h7F, 1'b1},
        '{8'h60, 8'hF8, 8'hFF, 8'hFF, 1'b1},
        '{8'h60, 8'hF9, 8'h01, 8'h01, 1'b1},
        '{8'h60, 8'hFA, 8'h33, 8'h00, 1'b1},
        '{8'h20, 8'hF7, 8'h12, 8'h00, 1'b1},
        '{8'h20, 8'hF8, 8'h00, 8'h00, 1'b1},
        '{8'hA0, 8'hF8, 8'h55, 8'h00, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic pull4, pull2;
    logic sda_bus;
    logic [3:0]  src4, snk4;
    logic [27:0] code4;
    logic [1:0]  src2, snk2;
    logic [13:0] code2;
    logic [7:0]  m4 [4];
    logic [7:0]  m2 [2];
    int checks = 0;
    int errors = 0;

    assign sda_bus = sda_m & ~pull4 & ~pull2;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_dac_bank #(.FOUR_CH(1'b1)) i_i2c_dac_bank (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
        .sda_pull_low(pull4), .addr_strap(2'b00),
        .src_en(src4), .snk_en(snk4), .dac_code(code4)
    );

    i2c_dac_bank #(.FOUR_CH(1'b0)) i_i2c_dac_bank_2ch (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
        .sda_pull_low(pull2), .addr_strap(2'b01),
        .src_en(src2), .snk_en(snk2), .dac_code(code2)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (QCLK) @(negedge clk);
    endtask

    // One SCL pulse carrying bit b; returns the bus level at mid-high.
    task automatic bus_bit(input logic b, output logic seen);
        sda_m = b; wq();
        scl = 1'b1; wq();
        seen = sda_bus; wq();
        scl = 1'b0; wq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            b[i] = s;
        end
        bus_bit(last, s);
    endtask

    task automatic do_write(input logic [7:0] dev, input logic [7:0] ptr,
                            input logic [7:0] data, output logic a0,
                            output logic a1, output logic a2);
        bus_start();
        send_byte(dev, a0);
        send_byte(ptr, a1);
        send_byte(data, a2);
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] dev, input logic [7:0] ptr,
                           input int nbytes, output logic [7:0] b0,
                           output logic [7:0] b1);
        logic a;
        bus_start();
        send_byte(dev, a);
        send_byte(ptr, a);
        bus_start();
        send_byte(dev | 8'h01, a);
        recv_byte(nbytes == 1, b0);
        b1 = b0;
        if (nbytes > 1) recv_byte(1'b1, b1);
        bus_stop();
    endtask

    function automatic logic [27:0] exp_code4();
        for (int i = 0; i < 4; i++) exp_code4[i*7 +: 7] = m4[i][6:0];
    endfunction

    function automatic logic [13:0] exp_code2();
        for (int i = 0; i < 2; i++) exp_code2[i*7 +: 7] = m2[i][6:0];
    endfunction

    function automatic logic [3:0] exp_dir4(input logic src);
        for (int i = 0; i < 4; i++)
            exp_dir4[i] = (m4[i][6:0] != 0) && (m4[i][7] == src);
    endfunction

    function automatic logic [1:0] exp_dir2(input logic src);
        for (int i = 0; i < 2; i++)
            exp_dir2[i] = (m2[i][6:0] != 0) && (m2[i][7] == src);
    endfunction

    // R4/R5: outputs of both banks against the bench model.
    task automatic check_outputs(input string req);
        chk(code4 == exp_code4(), {req, " R4 code4"}, 32'(code4), 32'(exp_code4()));
        chk(src4 == exp_dir4(1'b1) && snk4 == exp_dir4(1'b0), {req, " R5 dir4"},
            {24'd0, src4, snk4}, {24'd0, exp_dir4(1'b1), exp_dir4(1'b0)});
        chk(code2 == exp_code2(), {req, " R4 code2"}, 32'(code2), 32'(exp_code2()));
        chk(src2 == exp_dir2(1'b1) && snk2 == exp_dir2(1'b0), {req, " R5 dir2"},
            {28'd0, src2, snk2}, {28'd0, exp_dir2(1'b1), exp_dir2(1'b0)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic a0, a1, a2;
        logic [7:0] r0, r1;
        for (int i = 0; i < 4; i++) m4[i] = 8'h00;
        for (int i = 0; i < 2; i++) m2[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R6: reset state at the ports and by read-back
        check_outputs("R6 reset");
        chk(sda_bus == 1'b1, "R6 sda released", 32'(sda_bus), 32'd1);
        do_read(8'h20, 8'hFB, 1, r0, r1);
        chk(r0 == 8'h00, "R6 reset readback", 32'(r0), 32'h0);

        // Table walk: R1 R3 R4 R5 R7 R8 R2
        for (int v = 0; v < 10; v++) begin
            do_write(VECS[v].dev, VECS[v].ptr, VECS[v].data, a0, a1, a2);
            chk(a0 == VECS[v].ack_exp, "R1/R2 address ack", 32'(a0), 32'(VECS[v].ack_exp));
            if (VECS[v].ack_exp) begin
                chk(a1 && a2, "R3/R8 pointer+data ack", {30'd0, a1, a2}, 32'd3);
                if (VECS[v].dev == 8'h20 && VECS[v].ptr >= 8'hF8 && VECS[v].ptr <= 8'hFB)
                    m4[VECS[v].ptr - 8'hF8] = VECS[v].data;
                if (VECS[v].dev == 8'h60 && VECS[v].ptr >= 8'hF8 && VECS[v].ptr <= 8'hF9)
                    m2[VECS[v].ptr - 8'hF8] = VECS[v].data;
                do_read(VECS[v].dev, VECS[v].ptr, 1, r0, r1);
                chk(r0 == VECS[v].rd_exp, "R7/R8 readback", 32'(r0), 32'(VECS[v].rd_exp));
            end
            check_outputs("R3 table");
            chk(sda_bus == 1'b1, "R7 sda released after nack", 32'(sda_bus), 32'd1);
        end

        // R9: two data bytes in one write stay on the same register
        bus_start();
        send_byte(8'h20, a0);
        send_byte(8'hF9, a0);
        send_byte(8'h91, a1);
        send_byte(8'h22, a2);
        bus_stop();
        chk(a1 && a2, "R9 extra byte ack", {30'd0, a1, a2}, 32'd3);
        m4[1] = 8'h22;
        check_outputs("R9 no auto-increment");

        // R10: controller ACK yields the same register twice
        do_read(8'h20, 8'hF8, 2, r0, r1);
        chk(r0 == m4[0] && r1 == m4[0], "R10 repeated byte", {16'd0, r0, r1}, {16'd0, m4[0], m4[0]});

        // R2: after a mismatch, own address without START is ignored
        bus_start();
        send_byte(8'hE0, a0);
        send_byte(8'h20, a1);
        send_byte(8'hF8, a2);
        send_byte(8'h7A, a2);
        bus_stop();
        chk(!a0 && !a1 && !a2, "R2 ignore until START", {29'd0, a0, a1, a2}, 32'd0);
        check_outputs("R2 registers unchanged");

        // R1: after a new START the bank answers again
        do_write(8'h60, 8'hF8, 8'h83, a0, a1, a2);
        chk(a0 && a1 && a2, "R1 ack after new START", {29'd0, a0, a1, a2}, 32'd7);
        m2[0] = 8'h83;
        check_outputs("R1 strap 01 write");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule